// File: doc/BRIEF.md
# Interrupt-Level Flag Bank Switcher

This block holds the ALU condition flags (carry, sign, zero) for a small processor that services prioritised interrupts. It keeps one flag bank for normal execution and one for each interrupt level. Whichever context is running owns the active bank. The ALU's flag updates land only in that bank, and the block's output always shows that bank's contents.

When an interrupt routine is entered, the active bank switches to the bank of that routine's level. The index of the interrupted context is pushed onto a small stack. When a return-from-interrupt executes, the stack is popped and the interrupted context's bank becomes active again. Nested interrupts therefore unwind in order. Banks are never cleared by a switch, so a level's routine starts with whatever flags it held when it last exited.

Subroutine calls and plain returns run inside the current context and have no effect on any bank. Software reads the current flags through a status register at address 0x26.

Top module: `irq_flag_ctx`

## Requirements
- R1: After synchronous reset, the current context is 0 (normal mode) and every bank, including the one shown on `cur_flags`, holds 3'b000.
- R2: An accepted interrupt entry for level L (0..3) makes context L+1 current from the next cycle on. `cur_flags` then shows the values that bank L+1 last held.
- R3: An accepted return-from-interrupt makes the most recently interrupted context current again, with that context's flags unchanged. Nested entries unwind in last-in, first-out order.
- R4: A return-from-interrupt whose interrupted context was normal mode makes context 0 and the normal-mode flags current again.
- R5: Switching context never clears or changes a bank. A level's flags on re-entry equal the values it held when its routine last exited.
- R6: A flag write (`alu_flags_we`) stores `alu_flags` (bit0 carry, bit1 sign, bit2 zero) only into the bank of the context that is current in that cycle. This holds even when an entry or a return occurs in the same cycle.
- R7: `call_evt` and `ret_evt` change neither the current context nor any bank.
- R8: `status_data` equals {5'b0, zero, sign, carry} of the current context when `status_addr` is 8'h26, and 8'h00 for any other address.
- R9: A return with no interrupt active is ignored. An entry when four contexts are already stacked is ignored. When entry and return occur in the same cycle, the entry is taken and the return is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alu_flags_we | input | 1 | Write ALU flags into the current bank |
| alu_flags | input | 3 | New flags: bit0 carry, bit1 sign, bit2 zero |
| irq_enter | input | 1 | Interrupt routine entry event |
| irq_level | input | 2 | Level of the routine being entered |
| irq_exit | input | 1 | Return-from-interrupt event |
| call_evt | input | 1 | Subroutine call event |
| ret_evt | input | 1 | Plain subroutine return event |
| status_addr | input | 8 | Status read address |
| status_data | output | 8 | Status read data |
| cur_flags | output | 3 | Flags of the current context |
| cur_ctx | output | 3 | Current context: 0 normal, L+1 for level L |

## Verification
A directed nested scenario writes distinct flag patterns in normal mode and in two levels, then unwinds. This separates a per-level bank from a shared register, and LIFO unwinding from returning straight to normal mode. Re-entering a level after its exit shows whether banks survive switching. Same-cycle write-plus-entry and entry-plus-return cases pin down which context a write targets and which event wins. A long seeded random mix of entries, returns, writes, calls and status reads, including a full stack and returns on an empty stack, is compared cycle by cycle against a bench model of banks and a context stack.

// File: rtl/ctx_flags_pkg.sv
package ctx_flags_pkg;

    parameter int unsigned NUM_LEVELS = 4;
    parameter logic [7:0] STATUS_ADDR = 8'h26;

    typedef struct packed {
        logic zero;
        logic sign;
        logic carry;
    } flags_t;

    function automatic int unsigned ctx_count(input int unsigned levels);
        return levels + 1;
    endfunction

endpackage

// File: rtl/ctx_index_stack.sv
module ctx_index_stack #(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned W     = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] push_data,
    output logic [W-1:0] top,
    output logic         empty,
    output logic         full
);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_m1;

    assign cnt_m1 = cnt - 1'b1;
    assign empty  = (cnt == '0);
    assign full   = (cnt == CW'(DEPTH));
    assign top    = mem[cnt_m1[PW-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (push) begin
            mem[cnt[PW-1:0]] <= push_data;
            cnt <= cnt + 1'b1;
        end else if (pop) begin
            cnt <= cnt_m1;
        end
    end

    // R9: the caller must never push onto a full stack or pop an empty one
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
        !(push && full) && !(pop && empty));
    assert_depth_bound_R9: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));
endmodule

// File: rtl/flag_bank_array.sv
module flag_bank_array
    import ctx_flags_pkg::*;
#(
    parameter int unsigned NCTX = 5,
    parameter int unsigned CW   = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [CW-1:0] ctx,
    input  flags_t        wdata,
    output flags_t        rdata
);
    flags_t bank [NCTX];

    for (genvar g = 0; g < NCTX; g++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst) begin
                bank[g] <= '0;
            end else if (we && ctx == CW'(g)) begin
                bank[g] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NCTX; i++) begin
            if (ctx == CW'(i)) rdata = bank[i];
        end
    end
endmodule

// File: rtl/status_port.sv
module status_port
    import ctx_flags_pkg::*;
(
    input  logic [7:0] addr,
    input  flags_t     flags,
    output logic [7:0] data
);
    always_comb begin
        data = (addr == STATUS_ADDR) ? {5'b0, flags} : 8'h00;
    end

    // R8: decode of the status address
    always_comb begin
        if (addr != STATUS_ADDR) assert_status_zero_R8: assert (data == 8'h00);
    end
endmodule

// File: rtl/irq_flag_ctx.sv
module irq_flag_ctx
    import ctx_flags_pkg::*;
#(
    parameter int unsigned LEVELS = NUM_LEVELS,
    localparam int unsigned NCTX  = ctx_count(LEVELS),
    localparam int unsigned LW    = (LEVELS > 1) ? $clog2(LEVELS) : 1,
    localparam int unsigned CW    = $clog2(NCTX)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          alu_flags_we,
    input  logic [2:0]    alu_flags,
    input  logic          irq_enter,
    input  logic [LW-1:0] irq_level,
    input  logic          irq_exit,
    input  logic          call_evt,
    input  logic          ret_evt,
    input  logic [7:0]    status_addr,
    output logic [7:0]    status_data,
    output logic [2:0]    cur_flags,
    output logic [CW-1:0] cur_ctx
);
    logic [CW-1:0] ctx_q;
    logic [CW-1:0] stk_top;
    logic          stk_empty;
    logic          stk_full;
    logic          push_ok;
    logic          pop_ok;
    flags_t        rd_flags;

    assign push_ok = irq_enter && !stk_full;
    assign pop_ok  = irq_exit && !irq_enter && !stk_empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q <= '0;
        end else if (push_ok) begin
            ctx_q <= CW'(irq_level) + 1'b1;
        end else if (pop_ok) begin
            ctx_q <= stk_top;
        end
    end

    ctx_index_stack #(.DEPTH(LEVELS), .W(CW)) u_stack (
        .clk       (clk),
        .rst       (rst),
        .push      (push_ok),
        .pop       (pop_ok),
        .push_data (ctx_q),
        .top       (stk_top),
        .empty     (stk_empty),
        .full      (stk_full)
    );

    flag_bank_array #(.NCTX(NCTX), .CW(CW)) u_banks (
        .clk   (clk),
        .rst   (rst),
        .we    (alu_flags_we),
        .ctx   (ctx_q),
        .wdata (flags_t'(alu_flags)),
        .rdata (rd_flags)
    );

    status_port u_status (
        .addr  (status_addr),
        .flags (rd_flags),
        .data  (status_data)
    );

    assign cur_flags = rd_flags;
    assign cur_ctx   = ctx_q;

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (cur_ctx == '0 && cur_flags == 3'b000));
    assert_enter_ctx_R2: assert property (@(posedge clk) disable iff (rst)
        push_ok |=> cur_ctx == CW'($past(irq_level)) + 1'b1);
    assert_exit_ctx_R3: assert property (@(posedge clk) disable iff (rst)
        pop_ok |=> cur_ctx == $past(stk_top));
    assert_write_lands_R6: assert property (@(posedge clk) disable iff (rst)
        (alu_flags_we && !irq_enter && !irq_exit) |=> cur_flags == $past(alu_flags));
    assert_call_ret_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        ((call_evt || ret_evt) && !irq_enter && !irq_exit && !alu_flags_we)
        |=> ($stable(cur_flags) && $stable(cur_ctx)));
    assert_ignored_exit_R9: assert property (@(posedge clk) disable iff (rst)
        (irq_exit && !irq_enter && stk_empty) |=> cur_ctx == '0);
    assert_status_read_R8: assert property (@(posedge clk) disable iff (rst)
        (status_addr == STATUS_ADDR) |-> status_data == {5'b0, cur_flags});
endmodule

// File: tb/irq_flag_ctx_tb.sv
`timescale 1ns/1ps
module irq_flag_ctx_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       alu_flags_we = 1'b0;
    logic [2:0] alu_flags = '0;
    logic       irq_enter = 1'b0;
    logic [1:0] irq_level = '0;
    logic       irq_exit = 1'b0;
    logic       call_evt = 1'b0;
    logic       ret_evt = 1'b0;
    logic [7:0] status_addr = 8'h26;
    logic [7:0] status_data;
    logic [2:0] cur_flags;
    logic [2:0] cur_ctx;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic [2:0] mb [5];
    int         ms [$];
    int         mc;

    always #4 clk = ~clk;

    irq_flag_ctx u_dut (
        .clk(clk), .rst(rst), .alu_flags_we(alu_flags_we), .alu_flags(alu_flags),
        .irq_enter(irq_enter), .irq_level(irq_level), .irq_exit(irq_exit),
        .call_evt(call_evt), .ret_evt(ret_evt), .status_addr(status_addr),
        .status_data(status_data), .cur_flags(cur_flags), .cur_ctx(cur_ctx)
    );

    function automatic logic [7:0] exp_status(input logic [7:0] a, input logic [2:0] f);
        return (a == 8'h26) ? {5'b0, f} : 8'h00;
    endfunction

    task automatic chk(input string tag, input string what, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        chk(tag, "cur_ctx", int'(cur_ctx), mc);
        chk(tag, "cur_flags", int'(cur_flags), int'(mb[mc]));
        chk(tag, "status_data", int'(status_data), int'(exp_status(status_addr, mb[mc])));
    endtask

    task automatic model_step();
        if (alu_flags_we) mb[mc] = alu_flags;
        if (irq_enter) begin
            if (ms.size() < 4) begin
                ms.push_back(mc);
                mc = int'(irq_level) + 1;
            end
        end else if (irq_exit && ms.size() > 0) begin
            mc = ms.pop_back();
        end
    endtask

    task automatic cyc(input bit en, input int lvl, input bit ex, input bit we,
                       input logic [2:0] fl, input bit cl, input bit rt,
                       input logic [7:0] ad, input string tag);
        irq_enter = en; irq_level = 2'(lvl); irq_exit = ex;
        alu_flags_we = we; alu_flags = fl; call_evt = cl; ret_evt = rt;
        status_addr = ad;
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all(tag);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int seed = 32'h1BADC0DE;
        void'($urandom(seed));
        for (int i = 0; i < 5; i++) mb[i] = '0;
        mc = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        compare_all("R1");

        // directed nesting
        cyc(0,0,0,1,3'b101,0,0,8'h26,"R6");      // normal flags = 101
        cyc(1,2,0,0,3'b000,0,0,8'h26,"R2");      // enter level 2 -> ctx 3, flags 000
        cyc(0,0,0,1,3'b011,0,0,8'h26,"R6");
        cyc(1,0,0,0,3'b000,0,0,8'h26,"R2");      // nested level 0 -> ctx 1
        cyc(0,0,0,1,3'b110,0,0,8'h26,"R6");
        cyc(0,0,1,0,3'b000,0,0,8'h26,"R3");      // back to ctx 3, flags 011
        cyc(0,0,1,0,3'b000,0,0,8'h26,"R4");      // back to normal, flags 101
        cyc(1,2,0,0,3'b000,0,0,8'h26,"R5");      // re-enter level 2: flags 011 kept
        cyc(1,0,0,0,3'b000,0,0,8'h26,"R5");      // level 0 keeps 110
        cyc(0,0,1,0,3'b000,0,0,8'h26,"R3");
        cyc(0,0,1,0,3'b000,0,0,8'h26,"R4");
        // call / ret quiet
        cyc(0,0,0,0,3'b000,1,0,8'h26,"R7");
        cyc(0,0,0,0,3'b000,0,1,8'h26,"R7");
        cyc(0,0,0,0,3'b000,1,1,8'h26,"R7");
        // status decode
        cyc(0,0,0,0,3'b000,0,0,8'h25,"R8");
        cyc(0,0,0,0,3'b000,0,0,8'hA6,"R8");
        // write in the same cycle as entry goes to the old context
        cyc(1,1,0,1,3'b010,0,0,8'h26,"R6");
        cyc(0,0,1,1,3'b111,0,0,8'h26,"R6");      // write into level 1 bank, then exit
        cyc(1,1,0,0,3'b000,0,0,8'h26,"R6");      // level 1 shows 111
        cyc(0,0,1,0,3'b000,0,0,8'h26,"R4");      // normal shows 010
        // empty return, full stack, enter+exit together
        cyc(0,0,1,0,3'b000,0,0,8'h26,"R9");
        cyc(1,0,0,0,3'b000,0,0,8'h26,"R9");
        cyc(1,1,0,0,3'b000,0,0,8'h26,"R9");
        cyc(1,2,0,0,3'b000,0,0,8'h26,"R9");
        cyc(1,3,0,0,3'b000,0,0,8'h26,"R9");
        cyc(1,1,0,0,3'b000,0,0,8'h26,"R9");      // fifth entry ignored
        cyc(1,0,1,0,3'b000,0,0,8'h26,"R9");      // full: both ignored
        for (int i = 0; i < 3; i++) cyc(0,0,1,0,3'b000,0,0,8'h26,"R3");
        cyc(1,3,1,0,3'b000,0,0,8'h26,"R9");      // entry wins
        cyc(0,0,1,0,3'b000,0,0,8'h26,"R3");
        cyc(0,0,1,0,3'b000,0,0,8'h26,"R4");

        // seeded random mix
        for (int i = 0; i < 4000; i++) begin
            bit en = ($urandom % 100) < 15;
            bit ex = ($urandom % 100) < 17;
            bit we = ($urandom % 100) < 50;
            bit cl = ($urandom % 100) < 10;
            bit rt = ($urandom % 100) < 10;
            logic [7:0] ad = (($urandom % 8) == 0) ? 8'($urandom) : 8'h26;
            cyc(en, int'($urandom % 4), ex, we, 3'($urandom), cl, rt, ad, "R6");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule